// File: doc/BRIEF.md
# Two-Round Pipelined Keccak-f[1600] Permutation Core

This core applies the 24-round Keccak-f[1600] permutation to a 1600-bit state. The state is treated as twenty-five 64-bit lanes arranged on a 5×5 grid. The datapath holds two rounds back to back. Inside each round, a register separates the column-parity mixing step (theta) from the rest of the round: rotation, lane shuffle, non-linear row step and constant injection. As a result, one pass through the datapath takes four clock cycles and completes two rounds. The working state loops through the datapath twelve times.

A host drives a 1600-bit input state and pulses `start` while the core is idle. The core raises `busy` and computes for 48 cycles. It then copies the result into a held output register and pulses `done` for one cycle. Round constants are not stored inside the core. The core shows the number of the round it is finishing on `rcIdx`. An external source answers in the same cycle with a 7-bit compact constant on `rcBits`. The core expands those seven bits into the sparse 64-bit constant. Message padding, absorption and digest extraction belong to the surrounding logic.

Top module: `keccak_f2_pipe`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `busy` and `done` are 0 and `outState` is all zeros.
- R2: A `start` sampled while `busy` is 0 raises `busy` on the next cycle. `busy` then stays high for exactly 48 cycles, which is two stages for each of the 24 rounds.
- R3: `outState` equals Keccak-f[1600] applied to the `inState` captured with the accepted `start`. Lane (x,y) occupies bits [64*(x+5*y)+63 : 64*(x+5*y)]. Bit z of a lane is bit z of that slice. Rho rotates lanes to the left by the standard offsets, with offset 0 for lane (0,0).
- R4: For an all-zero input state, lane (0,0) of the result is 64'hF1258F7940E1DDE7.
- R5: `done` is high for exactly one cycle, in the first cycle in which `busy` is low again. It is never high on two consecutive cycles.
- R6: A `start` sampled while `busy` is 1 has no effect: it changes neither the running result nor the timing of `busy` and `done`.
- R7: `outState` changes only in the cycle in which `done` is high. Between completions, and throughout a run, it keeps the previous result.
- R8: In the k-th busy cycle after acceptance (k = 0..47), `rcIdx` equals 2*(k/4) + (1 if k mod 4 ≥ 2, else 0). The `rcBits` value present in that cycle is used for that round. Bit j of `rcBits` (j = 0..6) is XORed into bit 2^j − 1 of lane (0,0).
- R9: A `start` presented in the cycle in which `done` is high is accepted, so runs may follow each other with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a permutation of `inState` when idle |
| inState | input | 1600 | State to permute, lane (x,y) at bits 64*(x+5y) upward |
| busy | output | 1 | Permutation in progress |
| done | output | 1 | One-cycle pulse: `outState` has just been updated |
| outState | output | 1600 | Held result of the last completed permutation |
| rcIdx | output | 5 | Number of the round whose constant is needed now |
| rcBits | input | 7 | Compact round constant for round `rcIdx`, returned in the same cycle |

## Verification
The hardest behaviour to reach from the ports is a `start` arriving in unusual cycles. One case is a `start` during a run, which must leave that run untouched. The other is a `start` in the single cycle in which `done` is high, which must open a new run with no gap. The stimulus places one `start` in the middle of a run, using a state different from the one being processed. It then raises `start` again exactly on the `done` cycle. A behavioural model tracks `busy`, `done`, `rcIdx` and the held result on every clock, so a dropped, delayed or doubled acceptance becomes visible at once. An all-zero state is also run and compared against the known first output lane. This check exposes a wrong rotation table or a wrong constant expansion that a model sharing the same assumption might otherwise miss.

// File: rtl/keccak_f2_pkg.sv
package keccak_f2_pkg;

  localparam int LANE_W  = 64;
  localparam int LANES   = 25;
  localparam int RC_BITS = $clog2(LANE_W) + 1;

  typedef logic [LANES-1:0][LANE_W-1:0] kfState_t;

  typedef struct packed {
    logic load;
    logic capTheta1;
    logic capRound1;
    logic capTheta2;
    logic capRound2;
    logic capOut;
  } kfStrobe_t;

  // left-rotation amount per lane, indexed x + 5*y
  localparam int ROT_OFS [LANES] = '{
     0,  1, 62, 28, 27,
    36, 44,  6, 55, 20,
     3, 10, 43, 25, 39,
    41, 45, 15, 21,  8,
    18,  2, 61, 56, 14
  };

  function automatic logic [LANE_W-1:0] rotl(input logic [LANE_W-1:0] v, input int n);
    if (n == 0) return v;
    return (v << n) | (v >> (LANE_W - n));
  endfunction

  function automatic kfState_t thetaStep(input kfState_t s);
    logic [4:0][LANE_W-1:0] colPar;
    logic [LANE_W-1:0] mix;
    kfState_t r;
    for (int x = 0; x < 5; x++)
      colPar[x] = s[x] ^ s[x+5] ^ s[x+10] ^ s[x+15] ^ s[x+20];
    for (int x = 0; x < 5; x++) begin
      mix = colPar[(x+4)%5] ^ rotl(colPar[(x+1)%5], 1);
      for (int y = 0; y < 5; y++)
        r[x+5*y] = s[x+5*y] ^ mix;
    end
    return r;
  endfunction

  function automatic logic [LANE_W-1:0] expandRc(input logic [RC_BITS-1:0] c);
    logic [LANE_W-1:0] lane = '0;
    for (int j = 0; j < RC_BITS; j++)
      lane[(1 << j) - 1] = c[j];
    return lane;
  endfunction

  function automatic kfState_t restStep(input kfState_t s, input logic [RC_BITS-1:0] c);
    kfState_t b;
    kfState_t r;
    for (int x = 0; x < 5; x++)
      for (int y = 0; y < 5; y++)
        b[y + 5*((2*x + 3*y) % 5)] = rotl(s[x+5*y], ROT_OFS[x+5*y]);
    for (int y = 0; y < 5; y++)
      for (int x = 0; x < 5; x++)
        r[x+5*y] = b[x+5*y] ^ (~b[(x+1)%5 + 5*y] & b[(x+2)%5 + 5*y]);
    r[0] = r[0] ^ expandRc(c);
    return r;
  endfunction

endpackage

// File: rtl/kf_control.sv
module kf_control
  import keccak_f2_pkg::*;
#(
  parameter int ROUNDS = 24,
  localparam int PASSES = ROUNDS / 2,
  localparam int PASS_W = $clog2(PASSES),
  localparam int IDX_W  = PASS_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] rcIdx,
  output kfStrobe_t        strobe
);

  logic [1:0]        phase;
  logic [PASS_W-1:0] passCnt;
  logic              lastStep;

  assign lastStep = busy && (phase == 2'd3) && (passCnt == PASS_W'(PASSES - 1));
  assign rcIdx    = {passCnt, phase[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      phase   <= '0;
      passCnt <= '0;
    end else begin
      done <= lastStep;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          phase   <= '0;
          passCnt <= '0;
        end
      end else begin
        phase <= phase + 2'd1;
        if (phase == 2'd3) begin
          if (lastStep) busy    <= 1'b0;
          else          passCnt <= passCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.load      = start && !busy;
    strobe.capTheta1 = busy && (phase == 2'd0);
    strobe.capRound1 = busy && (phase == 2'd1);
    strobe.capTheta2 = busy && (phase == 2'd2);
    strobe.capRound2 = busy && (phase == 2'd3);
    strobe.capOut    = lastStep;
  end

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (rcIdx < IDX_W'(ROUNDS)));
  a_r8_idx_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (rcIdx >= $past(rcIdx)));
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !lastStep) |=> (busy && !done));
  a_r2_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.capTheta1, strobe.capRound1, strobe.capTheta2, strobe.capRound2}));

endmodule

// File: rtl/kf_datapath.sv
module kf_datapath
  import keccak_f2_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  kfStrobe_t          strobe,
  input  kfState_t           inState,
  input  logic [RC_BITS-1:0] rcBits,
  output kfState_t           outState
);

  kfState_t workReg;
  kfState_t theta1Reg;
  kfState_t round1Reg;
  kfState_t theta2Reg;
  kfState_t outReg;
  kfState_t round2Next;

  assign round2Next = restStep(theta2Reg, rcBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workReg   <= '0;
      theta1Reg <= '0;
      round1Reg <= '0;
      theta2Reg <= '0;
      outReg    <= '0;
    end else begin
      if (strobe.load)      workReg   <= inState;
      if (strobe.capTheta1) theta1Reg <= thetaStep(workReg);
      if (strobe.capRound1) round1Reg <= restStep(theta1Reg, rcBits);
      if (strobe.capTheta2) theta2Reg <= thetaStep(round1Reg);
      if (strobe.capRound2) workReg   <= round2Next;
      if (strobe.capOut)    outReg    <= round2Next;
    end
  end

  assign outState = outReg;

  a_r6_load_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !(strobe.capRound2 || strobe.capOut));

endmodule

// File: rtl/keccak_f2_pipe.sv
module keccak_f2_pipe
  import keccak_f2_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [1599:0] inState,
  output logic          busy,
  output logic          done,
  output logic [1599:0] outState,
  output logic [4:0]    rcIdx,
  input  logic [6:0]    rcBits
);

  kfStrobe_t strobe;
  kfState_t  resState;

  kf_control #(.ROUNDS(24)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .rcIdx  (rcIdx),
    .strobe (strobe)
  );

  kf_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inState  (kfState_t'(inState)),
    .rcBits   (rcBits),
    .outState (resState)
  );

  assign outState = resState;

  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(outState));
  a_r5_done_after_run: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

endmodule

// File: tb/keccak_f2_pipe_tb_top.sv
module keccak_f2_pipe_tb_top;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1599:0] inState = '0;
  logic          busy, done;
  logic [1599:0] outState;
  logic [4:0]    rcIdx;
  logic [6:0]    rcBits;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [6:0] rcTab [24];
  int         rhoTab [25];

  always #4 clk = ~clk;

  keccak_f2_pipe dut_i (
    .clk(clk), .rstN(rstN), .start(start), .inState(inState),
    .busy(busy), .done(done), .outState(outState),
    .rcIdx(rcIdx), .rcBits(rcBits)
  );

  // external compact constant source
  assign rcBits = (rcIdx < 5'd24) ? rcTab[rcIdx] : 7'd0;

  function automatic bit lfsrBit(input int t);
    logic [7:0] r = 8'h01;
    logic [8:0] w;
    for (int i = 0; i < t % 255; i++) begin
      w = {r, 1'b0};
      w[0] = w[0] ^ w[8];
      w[4] = w[4] ^ w[8];
      w[5] = w[5] ^ w[8];
      w[6] = w[6] ^ w[8];
      r = w[7:0];
    end
    return r[0];
  endfunction

  function automatic logic [63:0] rot(input logic [63:0] v, input int n);
    if (n == 0) return v;
    return (v << n) | (v >> (64 - n));
  endfunction

  function automatic logic [1599:0] refPerm(input logic [1599:0] s);
    logic [63:0] a [25];
    logic [63:0] b [25];
    logic [63:0] c [5];
    logic [63:0] d;
    logic [1599:0] res;
    for (int i = 0; i < 25; i++) a[i] = s[64*i +: 64];
    for (int rnd = 0; rnd < 24; rnd++) begin
      for (int x = 0; x < 5; x++) c[x] = a[x] ^ a[x+5] ^ a[x+10] ^ a[x+15] ^ a[x+20];
      for (int x = 0; x < 5; x++) begin
        d = c[(x+4)%5] ^ rot(c[(x+1)%5], 1);
        for (int y = 0; y < 5; y++) a[x+5*y] = a[x+5*y] ^ d;
      end
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          b[y + 5*((2*x+3*y)%5)] = rot(a[x+5*y], rhoTab[x+5*y]);
      for (int y = 0; y < 5; y++)
        for (int x = 0; x < 5; x++)
          a[x+5*y] = b[x+5*y] ^ (~b[(x+1)%5+5*y] & b[(x+2)%5+5*y]);
      for (int j = 0; j < 7; j++)
        a[0][(1<<j)-1] = a[0][(1<<j)-1] ^ rcTab[rnd][j];
    end
    for (int i = 0; i < 25; i++) res[64*i +: 64] = a[i];
    return res;
  endfunction

  initial begin
    int x, y, nx;
    for (int i = 0; i < 24; i++)
      for (int j = 0; j < 7; j++) rcTab[i][j] = lfsrBit(j + 7*i);
    rhoTab[0] = 0;
    x = 1; y = 0;
    for (int t = 0; t < 24; t++) begin
      rhoTab[x+5*y] = (((t+1)*(t+2))/2) % 64;
      nx = y;
      y = (2*x + 3*y) % 5;
      x = nx;
    end
  end

  // behavioural reference, advanced on each rising edge
  bit            mBusy = 0, mDone = 0;
  int            mCnt = 0;
  logic [1599:0] mOut = '0, mPending = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mCnt = 0; mOut = '0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        mCnt++;
        if (mCnt == 48) begin
          mBusy = 0; mDone = 1; mOut = mPending;
        end
      end else if (start) begin
        mBusy = 1; mCnt = 0; mPending = refPerm(inState);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    int expIdx;
    if (rstN && !finished) begin
      chk(busy == mBusy, "R2", "busy", 64'(busy), 64'(mBusy));
      chk(done == mDone, "R5", "done", 64'(done), 64'(mDone));
      chk(outState == mOut, "R3/R7", "outState lane0", outState[63:0], mOut[63:0]);
      if (mBusy) begin
        expIdx = 2*(mCnt/4) + (((mCnt%4) >= 2) ? 1 : 0);
        chk(rcIdx == 5'(expIdx), "R8", "rcIdx", 64'(rcIdx), 64'(expIdx));
      end
    end
  end

  task automatic pulseStart(input logic [1599:0] s);
    @(negedge clk);
    inState = s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  initial begin
    logic [1599:0] pat;
    logic [1599:0] expRes;
    repeat (3) @(negedge clk);
    // R1: reset values during and just after reset
    chk(busy == 0 && done == 0, "R1", "busy/done in reset", 64'({busy, done}), 64'd0);
    chk(outState == '0, "R1", "outState in reset", outState[63:0], 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && outState == '0, "R1", "after reset", 64'({busy, done}), 64'd0);

    // R4: all-zero state known answer
    pulseStart('0);
    waitDone();
    chk(outState[63:0] == 64'hF1258F7940E1DDE7, "R4", "zero-state lane0",
        outState[63:0], 64'hF1258F7940E1DDE7);
    expRes = refPerm('0);
    chk(outState == expRes, "R3", "zero-state full", outState[127:64], expRes[127:64]);

    // R3: single bit, all ones, random states
    pat = '0; pat[700] = 1'b1;
    pulseStart(pat);
    waitDone();
    chk(outState == refPerm(pat), "R3", "single-bit state", outState[63:0], mOut[63:0]);
    pulseStart({1600{1'b1}});
    waitDone();
    chk(outState == refPerm({1600{1'b1}}), "R3", "all-ones state", outState[63:0], mOut[63:0]);
    for (int i = 0; i < 50; i++) pat[32*i +: 32] = $urandom;
    pulseStart(pat);
    waitDone();
    chk(outState == refPerm(pat), "R3", "random state", outState[63:0], mOut[63:0]);

    // R6: start during a run with a different state is ignored
    for (int i = 0; i < 50; i++) pat[32*i +: 32] = $urandom;
    expRes = refPerm(pat);
    pulseStart(pat);
    repeat (17) @(negedge clk);
    inState = ~pat;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    chk(outState == expRes, "R6", "result after ignored start", outState[63:0], expRes[63:0]);

    // R9: start presented in the done cycle is accepted
    start = 1'b1;
    inState = {50{32'hA5C3_0F1E}};
    expRes = refPerm(inState);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start in done cycle", 64'(busy), 64'd1);
    waitDone();
    chk(outState == expRes, "R9", "back-to-back result", outState[63:0], expRes[63:0]);
    @(negedge clk);
    chk(done == 1'b0, "R5", "done falls after one cycle", 64'(done), 64'd0);
    // R7: output held while idle
    repeat (5) @(negedge clk);
    chk(outState == expRes, "R7", "held while idle", outState[63:0], expRes[63:0]);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule